// File: doc/BRIEF.md
# GPU Command Packet Framer

This block sits on the command port of a 2D graphics engine. Command words arrive one at a time, each 32 bits wide. The block groups them into whole command packets. The top byte of each packet's first word is the opcode, and the opcode fixes how many words belong to the packet. When the last word of a drawing packet is accepted, the block issues a one-cycle completion pulse. The pulse carries the opcode and the total word count. While the framer is idle, the renderer can read the held packet words through a random-access read port.

Some opcodes do not follow the fixed-length rule:

- **Line strips.** These have no fixed length. A line strip ends on a sentinel word. The sentinel is checked at word positions that depend on whether the strip is flat or shaded.
- **Image transfers.** These opcodes are never sent to the renderer. They are reduced to a start pulse with a position, a size and a direction, for a separate transfer engine.
- **Environment settings.** Eight single-word opcodes update shadow registers, which software can read back at any time.

If a line strip grows past the packet store, the block raises a sticky error. It then discards the strip up to its sentinel and resynchronises on the word that follows.

Top module: `gfx_cmd_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word. For opcodes 0x20–0x3F, the packet has 1 + N words, where N is 3, 6, 4, 8, 5, 8, 7 and 11 for the eight groups of four opcodes, taken in ascending order. `pkt_valid` pulses for one cycle, in the cycle after the last word is accepted. The pulse carries `pkt_opcode` and `pkt_words` = the total word count.
- R2: These opcodes take the following number of extra words:

  | Extra words | Opcodes |
  |---|---|
  | 3 | 0x80 |
  | 2 | 0x02, 0x40–0x47, 0x60–0x63, 0x74–0x77, 0x7C–0x7F |
  | 1 | 0x68–0x6B, 0x70–0x73, 0x78–0x7B |

  Opcodes 0x50–0x57 and 0x64–0x67 take 3 extra words. Opcodes 0x48–0x4F take 3 and opcodes 0x58–0x5F take 4 (see R3 and R4). Every other opcode outside the ranges in R5 and R6 is a one-word packet.
- R3: An opcode in 0x48–0x4F starts a flat line strip. The strip ends at the first word at index 3 or later (the first word is index 0) that satisfies (word & 0xF000F000) == 0x50005000. A matching word at index 1 or 2 does not end the strip. The count includes the sentinel.
- R4: An opcode in 0x58–0x5F starts a shaded line strip. The sentinel is tested only at even indices 4, 6, 8 and so on. A matching word at an odd index is an ordinary word.
- R5: An opcode in 0xA0–0xDF forms a three-word packet and never raises `pkt_valid`. One cycle after the third word is accepted, `xfer_start` pulses with the following values:
  - `xfer_pos` = word 1;
  - `xfer_size` = word 2;
  - `xfer_read` = 1 exactly when opcode bits 7:5 are 110.
- R6: An opcode in 0xE0–0xE7 is a one-word packet. It stores the whole word in environment register opcode[2:0] and does not raise `pkt_valid`. The new value is visible on `env_data` for `env_sel` from the next cycle.
- R7: After reset:
  - environment register i holds (0xE0+i) << 24;
  - `pkt_valid`, `xfer_start` and `ovf_err` are low;
  - any earlier environment writes are undone.
- R8: Idle cycles of any length between the words of a packet do not change its framing. No pulse occurs before the packet's last word.
- R9: After a completion pulse, `pkt_rd_data` returns packet word `pkt_rd_idx` until the next word is accepted.
- R10: A line strip can reach index DEPTH (default 16) before its sentinel. When that happens, `ovf_err` sets and stays set until reset. The strip produces no `pkt_valid`, and all words are consumed through the sentinel. The next word starts a fresh packet.
- R11: `in_ready` is low during reset and high otherwise. Every word with `in_valid` high outside reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word present |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted this cycle when valid |
| pkt_valid | output | 1 | One-cycle drawing packet completion pulse |
| pkt_opcode | output | 8 | Opcode of the completed packet |
| pkt_words | output | CNTW (5) | Total words in the completed packet |
| pkt_rd_idx | input | IDXW (4) | Word index for packet readback |
| pkt_rd_data | output | 32 | Held packet word at `pkt_rd_idx` |
| xfer_start | output | 1 | One-cycle image transfer start pulse |
| xfer_read | output | 1 | Transfer direction: 1 = read, 0 = write |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| env_sel | input | 3 | Environment register select |
| env_data | output | 32 | Selected environment register |
| ovf_err | output | 1 | Sticky line strip overflow flag |

## Verification
The framer's state is essentially the running word index of the current packet and its latched opcode. An error in either shows up at the ports at the end of the packet it affects:

- a miscounted index moves the `pkt_valid` pulse early or late by whole words, or changes `pkt_words`;
- a wrongly latched opcode puts the pulse on the transfer or environment path instead.

A framing slip does not heal by itself. Every later packet in the stream is then read from the wrong first word, so the bench places fixed-length packets directly after each line strip, each overflow and each transfer. A wrong sentinel parity shows up only on shaded strips that carry a matching word at an odd index, which the directed tests supply.

// File: rtl/gfx_framer_pkg.sv
package gfx_framer_pkg;

    localparam int WORD_W  = 32;
    localparam int OP_W    = 8;
    localparam int ENV_N   = 8;
    localparam int ENV_AW  = $clog2(ENV_N);
    localparam int LEN_W   = 5;

    localparam logic [WORD_W-1:0] TERM_MASK  = 32'hF000_F000;
    localparam logic [WORD_W-1:0] TERM_MATCH = 32'h5000_5000;

    typedef enum logic [2:0] {
        K_PLAIN,
        K_FLAT_LINE,
        K_SHADE_LINE,
        K_XFER,
        K_ENV
    } pkt_kind_e;

    typedef struct packed {
        pkt_kind_e        kind;
        logic [LEN_W-1:0] len;
    } op_info_t;

    // Extra words that follow the first word of a fixed-length packet.
    function automatic logic [3:0] extra_words(input logic [OP_W-1:0] op);
        logic [3:0] n;
        case (op) inside
            8'h02:          n = 4'd2;
            [8'h20:8'h23]:  n = 4'd3;
            [8'h24:8'h27]:  n = 4'd6;
            [8'h28:8'h2B]:  n = 4'd4;
            [8'h2C:8'h2F]:  n = 4'd8;
            [8'h30:8'h33]:  n = 4'd5;
            [8'h34:8'h37]:  n = 4'd8;
            [8'h38:8'h3B]:  n = 4'd7;
            [8'h3C:8'h3F]:  n = 4'd11;
            [8'h40:8'h47]:  n = 4'd2;
            [8'h48:8'h57]:  n = 4'd3;
            [8'h58:8'h5F]:  n = 4'd4;
            [8'h60:8'h63]:  n = 4'd2;
            [8'h64:8'h67]:  n = 4'd3;
            [8'h68:8'h6B]:  n = 4'd1;
            [8'h70:8'h73]:  n = 4'd1;
            [8'h74:8'h77]:  n = 4'd2;
            [8'h78:8'h7B]:  n = 4'd1;
            [8'h7C:8'h7F]:  n = 4'd2;
            8'h80:          n = 4'd3;
            default:        n = 4'd0;
        endcase
        return n;
    endfunction

    function automatic pkt_kind_e classify(input logic [OP_W-1:0] op);
        pkt_kind_e k;
        if (op >= 8'hA0 && op <= 8'hDF)
            k = K_XFER;
        else if (op[7:3] == 5'b11100)
            k = K_ENV;
        else if (op[7:3] == 5'b01001)
            k = K_FLAT_LINE;
        else if (op[7:3] == 5'b01011)
            k = K_SHADE_LINE;
        else
            k = K_PLAIN;
        return k;
    endfunction

    function automatic logic is_term(input logic [WORD_W-1:0] w);
        return (w & TERM_MASK) == TERM_MATCH;
    endfunction

    function automatic logic [WORD_W-1:0] env_reset_val(input int i);
        return {8'(8'hE0 + i), 24'h000000};
    endfunction

endpackage

// File: rtl/gfx_len_decode.sv
module gfx_len_decode
    import gfx_framer_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output op_info_t        info
);
    always_comb begin
        info.kind = classify(op);
        unique case (info.kind)
            K_XFER:  info.len = LEN_W'(3);
            K_ENV:   info.len = LEN_W'(1);
            default: info.len = LEN_W'(extra_words(op)) + LEN_W'(1);
        endcase
    end
endmodule

// File: rtl/gfx_word_buf.sv
module gfx_word_buf
    import gfx_framer_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (wr_en && wr_idx == IDXW'(g))
                mem[g] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/gfx_env_regs.sv
module gfx_env_regs
    import gfx_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ENV_AW-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ENV_AW-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] shadow [ENV_N];

    for (genvar g = 0; g < ENV_N; g++) begin : g_env
        always_ff @(posedge clk) begin
            if (rst)
                shadow[g] <= env_reset_val(g);
            else if (wr_en && wr_idx == ENV_AW'(g))
                shadow[g] <= wr_data;
        end
    end

    assign rd_data = shadow[rd_idx];
endmodule

// File: rtl/gfx_cmd_framer.sv
module gfx_cmd_framer
    import gfx_framer_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              pkt_valid,
    output logic [OP_W-1:0]   pkt_opcode,
    output logic [CNTW-1:0]   pkt_words,
    input  logic [IDXW-1:0]   pkt_rd_idx,
    output logic [WORD_W-1:0] pkt_rd_data,
    output logic              xfer_start,
    output logic              xfer_read,
    output logic [WORD_W-1:0] xfer_pos,
    output logic [WORD_W-1:0] xfer_size,
    input  logic [ENV_AW-1:0] env_sel,
    output logic [WORD_W-1:0] env_data,
    output logic              ovf_err
);
    // Framing state: word index of the next word, latched opcode, discard mode.
    logic [CNTW-1:0]   cnt_q;
    logic [OP_W-1:0]   op_q;
    logic              drop_q;
    logic [WORD_W-1:0] xpos_q;

    logic              accept;
    logic              busy;
    logic [OP_W-1:0]   cur_op;
    op_info_t          info;
    logic              term;
    logic              done;
    logic              ovf_now;
    logic              buf_we;
    logic              env_we;
    logic              is_draw;

    assign in_ready = !rst;                          // R11
    assign accept   = in_valid && in_ready;
    assign busy     = (cnt_q != '0);
    assign cur_op   = busy ? op_q : in_data[WORD_W-1 -: OP_W];
    assign term     = is_term(in_data);

    gfx_len_decode u_dec (
        .op   (cur_op),
        .info (info)
    );

    // End-of-packet detection per packet kind (R1, R2, R3, R4, R5, R6).
    always_comb begin
        unique case (info.kind)
            K_FLAT_LINE:  done = busy && (cnt_q >= CNTW'(3)) && term;
            K_SHADE_LINE: done = busy && (cnt_q >= CNTW'(4)) && !cnt_q[0] && term;
            K_ENV:        done = 1'b1;
            default:      done = ({1'b0, cnt_q} + (CNTW+1)'(1)) == (CNTW+1)'(info.len);
        endcase
    end

    assign is_draw = (info.kind == K_PLAIN) || (info.kind == K_FLAT_LINE) ||
                     (info.kind == K_SHADE_LINE);
    assign ovf_now = busy && !drop_q && (32'(cnt_q) >= DEPTH);        // R10
    assign buf_we  = accept && !drop_q && (32'(cnt_q) < DEPTH);
    assign env_we  = accept && !busy && (info.kind == K_ENV);         // R6

    gfx_word_buf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_we),
        .wr_idx  (IDXW'(cnt_q)),
        .wr_data (in_data),
        .rd_idx  (pkt_rd_idx),
        .rd_data (pkt_rd_data)
    );

    gfx_env_regs u_env (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (env_we),
        .wr_idx  (cur_op[ENV_AW-1:0]),
        .wr_data (in_data),
        .rd_idx  (env_sel),
        .rd_data (env_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            op_q       <= '0;
            drop_q     <= 1'b0;
            xpos_q     <= '0;
            pkt_valid  <= 1'b0;
            pkt_opcode <= '0;
            pkt_words  <= '0;
            xfer_start <= 1'b0;
            xfer_read  <= 1'b0;
            xfer_pos   <= '0;
            xfer_size  <= '0;
            ovf_err    <= 1'b0;
        end else begin
            pkt_valid  <= 1'b0;
            xfer_start <= 1'b0;
            if (accept) begin
                if (!busy)
                    op_q <= in_data[WORD_W-1 -: OP_W];
                if (info.kind == K_XFER && cnt_q == CNTW'(1))
                    xpos_q <= in_data;
                if (ovf_now)
                    ovf_err <= 1'b1;
                if (done) begin
                    cnt_q  <= '0;
                    drop_q <= 1'b0;
                    if (is_draw && !drop_q && !ovf_now) begin
                        pkt_valid  <= 1'b1;
                        pkt_opcode <= cur_op;
                        pkt_words  <= CNTW'(32'(cnt_q) + 1);
                    end
                    if (info.kind == K_XFER) begin
                        xfer_start <= 1'b1;
                        xfer_read  <= (cur_op[7:5] == 3'b110);
                        xfer_pos   <= xpos_q;
                        xfer_size  <= in_data;
                    end
                end else if (drop_q || ovf_now) begin
                    // Discard mode keeps only the index parity for the sentinel test.
                    drop_q <= 1'b1;
                    cnt_q  <= {cnt_q[CNTW-1:1], ~cnt_q[0]};
                end else begin
                    cnt_q <= cnt_q + CNTW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/gfx_framer_chk.sv
module gfx_framer_chk
    import gfx_framer_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              pkt_valid,
    input logic [CNTW-1:0]   pkt_words,
    input logic              xfer_start,
    input logic [ENV_AW-1:0] env_sel,
    input logic [WORD_W-1:0] env_data,
    input logic              ovf_err
);
    AST_XFER_NOT_DRAWN: assert property (@(posedge clk) disable iff (rst)
        !(pkt_valid && xfer_start));                                          // R5

    AST_XFER_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> $past(in_valid && in_ready));                          // R5

    AST_PULSE_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> $past(in_valid && in_ready));                           // R8

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (pkt_words != '0 && 32'(pkt_words) <= DEPTH));          // R1

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);                                                 // R10

    AST_ENV_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid && in_ready) && $stable(env_sel)) |-> $stable(env_data)); // R6
endmodule

bind gfx_cmd_framer gfx_framer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .pkt_valid  (pkt_valid),
    .pkt_words  (pkt_words),
    .xfer_start (xfer_start),
    .env_sel    (env_sel),
    .env_data   (env_data),
    .ovf_err    (ovf_err)
);

// File: tb/tb_gfx_cmd_framer.sv
module tb_gfx_cmd_framer;
    localparam int DEPTH = 16;
    localparam int IDXW  = $clog2(DEPTH);
    localparam int CNTW  = $clog2(DEPTH + 1);
    localparam int NVEC  = 25;

    // {opcode, expected total words}
    localparam logic [12:0] VEC [NVEC] = '{
        {8'h02, 5'd3},  {8'h20, 5'd4},  {8'h27, 5'd7},  {8'h2B, 5'd5},
        {8'h2C, 5'd9},  {8'h31, 5'd6},  {8'h36, 5'd9},  {8'h3A, 5'd8},
        {8'h3F, 5'd12}, {8'h40, 5'd3},  {8'h52, 5'd4},  {8'h60, 5'd3},
        {8'h65, 5'd4},  {8'h6A, 5'd2},  {8'h70, 5'd2},  {8'h75, 5'd3},
        {8'h79, 5'd2},  {8'h7E, 5'd3},  {8'h80, 5'd4},  {8'h00, 5'd1},
        {8'h1F, 5'd1},  {8'h6C, 5'd1},  {8'hE8, 5'd1},  {8'hFF, 5'd1},
        {8'h81, 5'd1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [31:0]     in_data = '0;
    logic            in_ready;
    logic            pkt_valid;
    logic [7:0]      pkt_opcode;
    logic [CNTW-1:0] pkt_words;
    logic [IDXW-1:0] pkt_rd_idx = '0;
    logic [31:0]     pkt_rd_data;
    logic            xfer_start;
    logic            xfer_read;
    logic [31:0]     xfer_pos;
    logic [31:0]     xfer_size;
    logic [2:0]      env_sel = '0;
    logic [31:0]     env_data;
    logic            ovf_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    bit  early;

    always #5 clk = ~clk;

    gfx_cmd_framer #(.DEPTH(DEPTH)) dut (
        .clk, .rst, .in_valid, .in_data, .in_ready,
        .pkt_valid, .pkt_opcode, .pkt_words, .pkt_rd_idx, .pkt_rd_data,
        .xfer_start, .xfer_read, .xfer_pos, .xfer_size,
        .env_sel, .env_data, .ovf_err
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one word for one edge; returns at the following falling edge.
    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        // R11: not ready during reset
        repeat (2) @(negedge clk);
        chk("R11 ready in reset", {31'b0, in_ready}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 ready after reset", {31'b0, in_ready}, 32'd1);

        // R7: reset state
        chk("R7 outputs idle", {29'b0, pkt_valid, xfer_start, ovf_err}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            env_sel = 3'(i);
            #1;
            chk("R7 env reset", env_data, {8'(8'hE0 + i), 24'h0});
        end

        // R1 / R2: fixed-length table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] op;
            int n;
            op = VEC[v][12:5];
            n  = int'(VEC[v][4:0]);
            early = 1'b0;
            for (int k = 0; k < n; k++) begin
                push(k == 0 ? {op, 24'h000111} : 32'h0000_0100 + 32'(k));
                if (k < n - 1 && pkt_valid) early = 1'b1;
            end
            chk(op < 8'h40 ? "R1 packet length" : "R2 packet length",
                {17'b0, pkt_valid, early, op, 5'(pkt_words)},
                {17'b0, 1'b1, 1'b0, op, 5'(n)});
            if (pkt_opcode !== op)
                chk("R1 opcode", {24'b0, pkt_opcode}, {24'b0, op});
        end

        // R3: flat line strip, matching word at index 2 is not a sentinel
        early = 1'b0;
        push(32'h4812_3456);
        push(32'h0001_0001); if (pkt_valid) early = 1'b1;
        push(32'h5500_5500); if (pkt_valid) early = 1'b1;
        push(32'h0002_0002); if (pkt_valid) early = 1'b1;
        push(32'h5ABC_5DEF);
        chk("R3 flat strip", {early, 1'b0, pkt_valid, 5'(pkt_words), pkt_opcode},
            {1'b0, 1'b0, 1'b1, 5'd5, 8'h48});
        // R9: readback of held words
        pkt_rd_idx = 4'd4; #1;
        chk("R9 readback last", pkt_rd_data, 32'h5ABC_5DEF);
        pkt_rd_idx = 4'd0; #1;
        chk("R9 readback first", pkt_rd_data, 32'h4812_3456);

        // R4: shaded strip, sentinel at odd index 5 is ignored, ends at 6
        early = 1'b0;
        push(32'h5A00_0000);
        for (int k = 1; k < 5; k++) begin
            push(32'h0000_0010 + 32'(k));
            if (pkt_valid) early = 1'b1;
        end
        push(32'h5000_5000); if (pkt_valid) early = 1'b1;
        push(32'h5000_5000);
        chk("R4 shaded strip", {early, pkt_valid, 5'(pkt_words), pkt_opcode},
            {1'b0, 1'b1, 5'd7, 8'h5A});

        // R5: image transfers
        push(32'hA000_0000);
        push(32'h0010_0020);
        push(32'h0008_0004);
        chk("R5 write xfer flags", {30'b0, xfer_start, pkt_valid}, {30'b0, 1'b1, 1'b0});
        chk("R5 write dir", {31'b0, xfer_read}, 32'd0);
        chk("R5 pos", xfer_pos, 32'h0010_0020);
        chk("R5 size", xfer_size, 32'h0008_0004);
        push(32'hC500_0000);
        push(32'h0001_0002);
        push(32'h0003_0004);
        chk("R5 read xfer", {30'b0, xfer_start, xfer_read}, {30'b0, 1'b1, 1'b1});
        push(32'hBF00_0000);
        push(32'h0);
        push(32'h0);
        chk("R5 0xBF is write", {30'b0, xfer_start, xfer_read}, {30'b0, 1'b1, 1'b0});
        push(32'h2000_0000); push(32'h1); push(32'h2); push(32'h3);
        chk("R5 framing after xfer", {26'b0, pkt_valid, 5'(pkt_words)}, {26'b0, 1'b1, 5'd4});

        // R6: environment capture
        push(32'hE301_2345);
        chk("R6 no pulse", {31'b0, pkt_valid}, 32'd0);
        env_sel = 3'd3; #1;
        chk("R6 env write", env_data, 32'hE301_2345);
        push(32'hE7AB_CDEF);
        env_sel = 3'd7; #1;
        chk("R6 env write 7", env_data, 32'hE7AB_CDEF);
        env_sel = 3'd3; #1;
        chk("R6 env other kept", env_data, 32'hE301_2345);

        // R8: long gaps between words
        early = 1'b0;
        push(32'h2400_0000);
        for (int k = 1; k < 7; k++) begin
            repeat (5) begin
                @(negedge clk);
                if (pkt_valid) early = 1'b1;
            end
            push(32'h0000_0000 + 32'(k));
            if (k < 6 && pkt_valid) early = 1'b1;
        end
        chk("R8 gapped packet", {25'b0, early, pkt_valid, 5'(pkt_words)}, {25'b0, 1'b0, 1'b1, 5'd7});

        // R10: overflow of the packet store
        early = 1'b0;
        push(32'h4900_0000);
        for (int k = 1; k < 20; k++) begin
            push(32'h0001_0001);
            if (pkt_valid) early = 1'b1;
            if (k == DEPTH - 1)
                chk("R10 no error at store limit", {31'b0, ovf_err}, 32'd0);
        end
        chk("R10 error set", {31'b0, ovf_err}, 32'd1);
        push(32'h5000_5000);
        if (pkt_valid) early = 1'b1;
        chk("R10 strip dropped", {31'b0, early}, 32'd0);
        push(32'h0200_0000); push(32'h1); push(32'h2);
        chk("R10 resync", {25'b0, ovf_err, pkt_valid, 5'(pkt_words)}, {25'b0, 1'b1, 1'b1, 5'd3});

        // R7: reset clears error and environment writes
        do_reset();
        env_sel = 3'd3; #1;
        chk("R7 env restored", env_data, 32'hE300_0000);
        chk("R7 error cleared", {31'b0, ovf_err}, 32'd0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule